// File: doc/BRIEF.md
# Serial EEPROM Write Slave

This block is the write half of a byte-addressed serial EEPROM that sits on a two-wire bus. A separate bit-level front end turns the bus wires into single-cycle strobes: Start, Stop, one strobe per received bit with its value, and one strobe for the acknowledge slot. The block expects three kinds of byte in order. The first is a control byte that names the device and asks for a write. Then come two word-address bytes. After those, any number of data bytes may arrive. Data bytes collect in a 32-entry page buffer. When a Stop arrives on a byte boundary, the buffered bytes are copied into a 4096 x 8 storage array during an internal write cycle of fixed length.

The write cycle is timed by a counter of `WRITE_CYCLES` clocks. During that time the slave is busy, and it refuses every control byte by not acknowledging it. A host can therefore poll for completion by sending a write control byte until it is acknowledged. The write-protect input is sampled once, at the Stop. When it is high, the transaction is acknowledged in full but the array is left untouched. A combinational inspection port reads the array directly.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A control byte is acknowledged only if bits 7:4 are 1010, bits 3:1 equal `chipSel`, bit 0 (read/write) is 0, and the slave is not busy. Any other control byte is not acknowledged. After it, every byte up to the next Start is ignored and not acknowledged, and no write takes place.
- R2: For an accepted byte, `ackOut` goes high on the second clock after the eighth bit strobe. It stays high until the ninth strobe of that byte (the acknowledge slot) and drops on the clock after that strobe.
- R3: The word address is 12 bits. The low 4 bits of the first address byte form address bits 11:8, and the second address byte forms bits 7:0. The upper 4 bits of the first address byte have no effect.
- R4: Each data byte is stored at the pointer position within the 32-byte page. Only pointer bits 4:0 then increment, wrapping from 31 to 0. More than 32 bytes overwrite earlier buffered bytes, and bits 11:5 never change.
- R5: The write cycle starts only when Stop arrives on a byte boundary after at least one data byte, with write protect low. `busy` is high for exactly `WRITE_CYCLES` clocks starting the clock after that Stop, and the array holds the new bytes when `busy` falls.
- R6: While `busy` is high, a write control byte is not acknowledged. Once `busy` has fallen, the same byte is acknowledged.
- R7: If `wpIn` is high at the Stop, every byte is still acknowledged, but `busy` stays low and the array is unchanged. A change of `wpIn` after the Stop does not affect a write cycle that has already started.
- R8: Only the buffer positions that received a byte in the transaction are written. All other locations of the page keep their contents.
- R9: After the data bytes, `ptrOut` holds the address following the last byte written, wrapped within the page. After a single-byte write this is the written address plus one.
- R10: A Start or Stop that arrives while a byte is partly received (bits or the acknowledge slot pending) ends the transaction, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start condition seen (one clock) |
| stopStb | input | 1 | Stop condition seen (one clock) |
| bitStb | input | 1 | One bus clock: data bit or acknowledge slot |
| bitVal | input | 1 | Bus data value at `bitStb` |
| chipSel | input | 3 | Strapped chip-select value |
| wpIn | input | 1 | Write protect, sampled at Stop |
| peekAddr | input | ADDR_W | Array inspection address |
| ackOut | output | 1 | Drive acknowledge on the bus |
| busy | output | 1 | Internal write cycle in progress |
| ptrOut | output | ADDR_W | Current address pointer |
| peekData | output | 8 | Array contents at `peekAddr` |

## Verification
The page write is tried in several forms, each separating one pointer rule from its neighbours:
- A single byte shows whether the pointer moves on by one.
- A full 32-byte page starting on its boundary, with garbage in the upper address nibble, shows that those four bits are dropped.
- A 40-byte burst from the middle of a page shows whether the low five bits wrap and overwrite without spilling into the next page.
- A three-byte write across the page end shows that the valid mask leaves untouched bytes alone.

Refusal is exercised through wrong chip-select, wrong device code, read requests and polling during the cycle. Write protect is tested both high at Stop and raised just after it. Aborts are tested with a Stop and with a Start in the middle of a byte.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_ADRH, S_ADRL, S_DATA, S_WAIT
  } ewr_state_e;

  typedef struct packed {
    logic shiftEn;
    logic loadHi;
    logic loadLo;
    logic storeByte;
    logic clearBuf;
    logic commitEn;
  } ewr_strobe_t;
endpackage

// File: rtl/ewr_ctrl.sv
module ewr_ctrl
  import ewr_pkg::*;
#(
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              bitStb,
  input  logic [2:0]        chipSel,
  input  logic              wpIn,
  input  logic [7:0]        rxByte,
  input  logic              anyValid,
  output ewr_strobe_t       stb,
  output logic [PAGE_W-1:0] commitIdx,
  output logic              ackOut,
  output logic              busy
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CYC_W = $clog2(WRITE_CYCLES + 1);

  ewr_state_e       st;
  logic [3:0]       bitCnt;
  logic             byteRdy;
  logic [CYC_W-1:0] cycCnt;
  logic             recv;
  logic             accept;
  logic             commitGo;
  logic             lastCyc;

  assign recv     = (st == S_CTRL) || (st == S_ADRH) || (st == S_ADRL) || (st == S_DATA);
  assign commitGo = stopStb && !startStb && (st == S_DATA) && (bitCnt == 4'd0) &&
                    !byteRdy && anyValid && !wpIn && !busy;
  assign lastCyc  = busy && (cycCnt == CYC_W'(WRITE_CYCLES - 1));

  always_comb begin
    accept = 1'b1;
    if (st == S_CTRL)
      accept = (rxByte[7:4] == 4'b1010) && (rxByte[3:1] == chipSel) && !rxByte[0] && !busy;
  end

  always_comb begin
    stb           = '0;
    stb.shiftEn   = bitStb && recv && (bitCnt < 4'd8) && !startStb && !stopStb;
    stb.loadHi    = byteRdy && (st == S_ADRH) && !startStb && !stopStb;
    stb.loadLo    = byteRdy && (st == S_ADRL) && !startStb && !stopStb;
    stb.storeByte = byteRdy && (st == S_DATA) && !startStb && !stopStb;
    stb.clearBuf  = (startStb && !busy) || lastCyc;
    stb.commitEn  = busy && (cycCnt < CYC_W'(PAGE));
    commitIdx     = cycCnt[PAGE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      bitCnt  <= '0;
      byteRdy <= 1'b0;
      ackOut  <= 1'b0;
      busy    <= 1'b0;
      cycCnt  <= '0;
    end else begin
      if (busy) begin
        if (lastCyc) busy <= 1'b0;
        else         cycCnt <= cycCnt + 1'b1;
      end
      if (startStb) begin
        st      <= S_CTRL;
        bitCnt  <= '0;
        byteRdy <= 1'b0;
        ackOut  <= 1'b0;
      end else if (stopStb) begin
        st      <= S_IDLE;
        bitCnt  <= '0;
        byteRdy <= 1'b0;
        ackOut  <= 1'b0;
        if (commitGo) begin
          busy   <= 1'b1;
          cycCnt <= '0;
        end
      end else begin
        byteRdy <= stb.shiftEn && (bitCnt == 4'd7);
        if (stb.shiftEn) bitCnt <= bitCnt + 1'b1;
        if (byteRdy) begin
          ackOut <= accept;
          if (!accept) st <= S_WAIT;
          else begin
            case (st)
              S_CTRL:  st <= S_ADRH;
              S_ADRH:  st <= S_ADRL;
              S_ADRL:  st <= S_DATA;
              default: st <= st;
            endcase
          end
        end
        if (bitStb && recv && (bitCnt == 4'd8)) begin
          bitCnt <= '0;
          ackOut <= 1'b0;
        end
      end
    end
  end

  // R2: acknowledge is only driven while waiting for the ninth clock
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (bitCnt == 4'd8));

  // R6: a control byte decoded during the write cycle is never acknowledged
  p_nack_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (byteRdy && (st == S_CTRL) && busy && !startStb && !stopStb) |=> !ackOut);

  // R5: a write cycle only ever begins from an unprotected Stop
  p_commit_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(stopStb) && !$past(wpIn)));

  // R7: a protected Stop leaves the slave ready at once
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && wpIn && !busy) |=> !busy);

  // R10: a Stop inside a byte never starts a write
  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && (bitCnt != 4'd0) && !busy) |=> !busy);
endmodule

// File: rtl/ewr_datapath.sv
module ewr_datapath
  import ewr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitVal,
  input  ewr_strobe_t       stb,
  input  logic [PAGE_W-1:0] commitIdx,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        rxByte,
  output logic              anyValid,
  output logic [ADDR_W-1:0] ptrOut,
  output logic [7:0]        peekData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [7:0]        shiftReg;
  logic [HI_W-1:0]   hiReg;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   validMask;
  logic [7:0]        pageBuf [PAGE];
  logic [7:0]        mem     [DEPTH];
  logic [PAGE_W-1:0] slot;

  assign slot     = ptr[PAGE_W-1:0];
  assign rxByte   = shiftReg;
  assign anyValid = |validMask;
  assign ptrOut   = ptr;
  assign peekData = mem[peekAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      hiReg     <= '0;
      ptr       <= '0;
      validMask <= '0;
    end else begin
      if (stb.shiftEn) shiftReg <= {shiftReg[6:0], bitVal};
      if (stb.loadHi)  hiReg    <= shiftReg[HI_W-1:0];
      if (stb.loadLo)  ptr      <= {hiReg, shiftReg};
      if (stb.clearBuf) validMask <= '0;
      else if (stb.storeByte) validMask[slot] <= 1'b1;
      if (stb.storeByte) ptr[PAGE_W-1:0] <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) pageBuf[slot] <= shiftReg;
  end

  always_ff @(posedge clk) begin
    if (stb.commitEn && validMask[commitIdx])
      mem[{ptr[ADDR_W-1:PAGE_W], commitIdx}] <= pageBuf[commitIdx];
  end

  // R4: storing a byte never moves the pointer out of its page
  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeByte |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R8: a received byte marks its own slot as pending
  p_mark_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.storeByte && !stb.clearBuf) |=> anyValid);
endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
  import ewr_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              bitStb,
  input  logic              bitVal,
  input  logic [2:0]        chipSel,
  input  logic              wpIn,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic              ackOut,
  output logic              busy,
  output logic [ADDR_W-1:0] ptrOut,
  output logic [7:0]        peekData
);
  ewr_strobe_t       stb;
  logic [PAGE_W-1:0] commitIdx;
  logic [7:0]        rxByte;
  logic              anyValid;

  ewr_ctrl #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .bitStb(bitStb), .chipSel(chipSel), .wpIn(wpIn), .rxByte(rxByte),
    .anyValid(anyValid), .stb(stb), .commitIdx(commitIdx),
    .ackOut(ackOut), .busy(busy)
  );

  ewr_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_data (
    .clk(clk), .rstN(rstN), .bitVal(bitVal), .stb(stb),
    .commitIdx(commitIdx), .peekAddr(peekAddr), .rxByte(rxByte),
    .anyValid(anyValid), .ptrOut(ptrOut), .peekData(peekData)
  );
endmodule

// File: tb/eeprom_wr_slave_bench.sv
module eeprom_wr_slave_bench;
  localparam int AW = 12;
  localparam int WC = 40;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] CTRL_WR = {4'b1010, CS, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0, stopStb = 1'b0, bitStb = 1'b0, bitVal = 1'b0;
  logic wpIn = 1'b0;
  logic [AW-1:0] peekAddr = '0;
  logic ackOut, busy;
  logic [AW-1:0] ptrOut;
  logic [7:0] peekData;

  int nChecks = 0;
  int nErr = 0;
  int left = 0;
  logic expCommit = 1'b0;
  int expMem [4096];

  always #4 clk = ~clk;

  eeprom_wr_slave #(.ADDR_W(AW), .PAGE_W(5), .WRITE_CYCLES(WC)) u_eeprom_wr_slave (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .bitStb(bitStb), .bitVal(bitVal), .chipSel(CS), .wpIn(wpIn),
    .peekAddr(peekAddr), .ackOut(ackOut), .busy(busy), .ptrOut(ptrOut),
    .peekData(peekData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference busy model: R5 window of WC clocks after a committing Stop
  always @(posedge clk) begin
    if (!rstN) left <= 0;
    else if (stopStb && expCommit) left <= WC;
    else if (left > 0) left <= left - 1;
  end

  always @(negedge clk) begin
    if (rstN) chk(busy === (left > 0), "R5 busy", int'(busy), int'(left > 0));
  end

  task automatic pulseBit(input logic v);
    @(negedge clk); bitVal = v; bitStb = 1'b1;
    @(negedge clk); bitStb = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) pulseBit(b[i]);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    sendBits(b, 8);
    @(negedge clk);
    chk(ackOut === expAck, req, int'(ackOut), int'(expAck));
    pulseBit(1'b0);
    chk(ackOut === 1'b0, "R2 release", int'(ackOut), 0);
  endtask

  task automatic doStart();
    @(negedge clk); startStb = 1'b1;
    @(negedge clk); startStb = 1'b0;
    @(negedge clk);
  endtask

  task automatic doStop(input logic commit);
    @(negedge clk); stopStb = 1'b1; expCommit = commit;
    @(negedge clk); stopStb = 1'b0; expCommit = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] dat(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  // Write transaction; model applies bytes within the page (R4, R8)
  task automatic writeTxn(input int addr, input int n, input int seed,
                          input logic wp, input logic [3:0] junk);
    doStart();
    sendByte(CTRL_WR, 1'b1, "R1 ctrl");
    sendByte({junk, 4'(addr >> 8)}, 1'b1, "R3 addr hi");
    sendByte(8'(addr), 1'b1, "R2 addr lo");
    for (int i = 0; i < n; i++) sendByte(dat(seed, i), 1'b1, "R7 data ack");
    chk(ptrOut === AW'((addr & 12'hFE0) | ((addr + n) & 31)), "R9 ptr",
        int'(ptrOut), (addr & 12'hFE0) | ((addr + n) & 31));
    wpIn = wp;
    doStop(!wp && n > 0);
    if (!wp)
      for (int i = 0; i < n; i++) expMem[(addr & 12'hFE0) | ((addr + i) & 31)] = dat(seed, i);
  endtask

  task automatic checkPage(input int base, input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); peekAddr = AW'(base + i);
      @(negedge clk);
      chk(int'(peekData) == expMem[base + i], req, int'(peekData), expMem[base + i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && ackOut === 1'b0, "R5 reset", int'({busy, ackOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ptrOut === '0, "R9 reset ptr", int'(ptrOut), 0);

    // R3: prefill pages, garbage in upper nibble of the high address byte
    writeTxn(12'h3E0, 32, 8'h10, 1'b0, 4'hF); waitIdle();
    checkPage(12'h3E0, "R3 prefill");
    writeTxn(12'h100, 32, 8'h80, 1'b0, 4'h9); waitIdle();
    checkPage(12'h100, "R5 prefill");

    // R9: single byte write
    writeTxn(12'h3E5, 1, 8'h5A, 1'b0, 4'h0); waitIdle();
    checkPage(12'h3E0, "R9 byte write");

    // R4: 40 bytes from mid-page wrap and overwrite
    writeTxn(12'h110, 40, 8'h33, 1'b0, 4'h0); waitIdle();
    checkPage(12'h100, "R4 page wrap");
    checkPage(12'h3E0, "R4 other page");

    // R8: three bytes across the page end, rest untouched
    writeTxn(12'h11E, 3, 8'hC1, 1'b0, 4'h0); waitIdle();
    checkPage(12'h100, "R8 partial");

    // R7: protected at Stop
    writeTxn(12'h3E8, 4, 8'h55, 1'b1, 4'h0); wpIn = 1'b0; waitIdle();
    checkPage(12'h3E0, "R7 protected");

    // R7: protect raised just after Stop; R6: polling while busy
    writeTxn(12'h3F0, 5, 8'h21, 1'b0, 4'h0);
    wpIn = 1'b1;
    doStart(); sendByte(CTRL_WR, 1'b0, "R6 poll busy"); doStop(1'b0);
    waitIdle(); wpIn = 1'b0;
    checkPage(12'h3E0, "R7 late protect");
    doStart(); sendByte(CTRL_WR, 1'b1, "R6 poll ready"); doStop(1'b0);

    // R1: wrong chip select, wrong device code, read request
    doStart();
    sendByte({4'b1010, 3'b011, 1'b0}, 1'b0, "R1 bad cs");
    sendByte(8'h01, 1'b0, "R1 ignored hi");
    sendByte(8'h04, 1'b0, "R1 ignored lo");
    sendByte(8'hEE, 1'b0, "R1 ignored data");
    doStop(1'b0);
    doStart(); sendByte({4'b1011, CS, 1'b0}, 1'b0, "R1 bad code"); doStop(1'b0);
    doStart(); sendByte({4'b1010, CS, 1'b1}, 1'b0, "R1 read req"); doStop(1'b0);
    checkPage(12'h100, "R1 no write");

    // R10: Stop inside a byte
    doStart();
    sendByte(CTRL_WR, 1'b1, "R10 ctrl");
    sendByte(8'h01, 1'b1, "R10 hi");
    sendByte(8'h08, 1'b1, "R10 lo");
    sendByte(8'h77, 1'b1, "R10 data");
    sendBits(8'h99, 4);
    doStop(1'b0);
    // R10: Start inside a byte
    doStart();
    sendByte(CTRL_WR, 1'b1, "R10 ctrl2");
    sendByte(8'h01, 1'b1, "R10 hi2");
    sendByte(8'h0A, 1'b1, "R10 lo2");
    sendByte(8'h66, 1'b1, "R10 data2");
    sendBits(8'h44, 3);
    doStart();
    doStop(1'b0);
    // R5: Stop straight after the address, no data
    doStart();
    sendByte(CTRL_WR, 1'b1, "R5 ctrl");
    sendByte(8'h01, 1'b1, "R5 hi");
    sendByte(8'h0C, 1'b1, "R5 lo");
    doStop(1'b0);
    repeat (4) @(negedge clk);
    checkPage(12'h100, "R10 no write");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule